// File: doc/BRIEF.md
# Interleaved Monochrome Frame Refresh and Drawing Memory Controller

This block lets a screen refresh engine and a drawing engine share one 16-bit-wide video memory that has a shared address/data bus. Time on the memory is cut into display periods of 16 pixel clocks. The first half of every period belongs to refresh: one 16-bit word of 1-bit-per-pixel image data is fetched. The second half belongs to a drawing port, which may read or write any word of the memory. This includes the words above the frame buffer that hold fonts, patterns and other objects. Refresh and drawing therefore never wait on each other.

Each fetched word is loaded into a parallel-to-serial shifter and sent out one pixel per clock, most significant bit first. Horizontal and vertical counters produce active-low sync pulses. Pixels outside the visible region are forced to 0. The sync outputs are delayed so that they line up with the serialized pixels. With default parameters the raster is 640 by 480, with 40 word fetches per visible line, and the frame occupies 38,400 bytes of a 64 KB memory.

In the text below, a "position" is the clock count since the end of reset, taken modulo 16. This equals the horizontal counter modulo 16.

Top module: `mono_vram_ctrl`

## Requirements
- R1: While reset is held, the block drives the following values: pix_out=0, hsync_n=1, vsync_n=1, mem_ale=0, mem_we=0, draw_ack=0 and draw_rvalid=0.
- R2: For every 16-clock period whose pixels are visible, mem_ale is high at position 1 and mem_ad_out carries the display word address, zero-extended. The address starts at disp_base at the top of each frame and increases by one per visible period, continuing across lines.
- R3: The visible pixel at column h, line v appears on pix_out 17 clocks after the raster counters reach (h, v). Its value is bit 15-(h mod 16) of the word at disp_base + v*(H_ACT/16) + h/16.
- R4: pix_out is 0 whenever the pixel position it shows lies outside the visible H_ACT by V_ACT region.
- R5: hsync_n is low for the H_SW pixel positions that start H_ACT+H_FP columns into each line, using the same 17-clock alignment as pix_out.
- R6: vsync_n is low for the V_SW whole lines that start V_ACT+V_FP lines into each frame, using the same alignment as pix_out.
- R7: A draw_req that is high at position 7 receives a one-clock draw_ack at position 8. A request raised at any other position waits until the next position 8 to be acknowledged.
- R8: For an acknowledged write (draw_we=1), the block drives mem_ale at position 9 with the draw address, then mem_we at position 10 with draw_wdata on mem_ad_out. This works for any address, including those beyond the frame buffer.
- R9: For an acknowledged read, draw_rvalid pulses for one clock at position 12. At that clock draw_rdata holds the addressed memory word.
- R10: mem_ale appears only at positions 1 and 9, and mem_we only at position 10. A drawing write to a word inside the frame is shown on the display from the following frame on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| disp_base | input | ADDR_W | Word address of the first frame word, taken at each frame start |
| draw_req | input | 1 | Drawing access request, held until acknowledged |
| draw_we | input | 1 | 1 = write, 0 = read |
| draw_addr | input | ADDR_W | Drawing word address |
| draw_wdata | input | 16 | Drawing write data |
| draw_ack | output | 1 | One-clock acceptance of the request |
| draw_rdata | output | 16 | Read data |
| draw_rvalid | output | 1 | One-clock strobe qualifying draw_rdata |
| mem_ale | output | 1 | Address latch enable; mem_ad_out holds the address |
| mem_ad_oe | output | 1 | Controller is driving the shared bus |
| mem_we | output | 1 | Write strobe; mem_ad_out holds the data |
| mem_ad_out | output | 16 | Outgoing address or data on the shared bus |
| mem_ad_in | input | 16 | Data driven by memory at the latched address |
| pix_out | output | 1 | Serial pixel, blanked outside the visible region |
| hsync_n | output | 1 | Horizontal sync, active low |
| vsync_n | output | 1 | Vertical sync, active low |

## Verification
The properties assume that the requester holds draw_req steady until it sees draw_ack and then drops it. They also assume that memory returns data combinationally from the most recently latched address. The bench drives the drawing port only through a task that follows this handshake. It models the memory as a latch-and-array that reacts only to mem_ale and mem_we. The bench changes no frame word while pixels are being compared. It resumes comparison only at a frame boundary after the drawing writes have finished, so the expected picture is always the one the block had the chance to fetch.

// File: rtl/vram_pkg.sv
package vram_pkg;

  // Bus word and pixels per fetch are the same quantity: one bit per pixel.
  localparam int WORD_W  = 16;
  // Clocks from the decode of an address phase to the capture of read data.
  localparam int CAP_LAG = 3;

  typedef struct packed {
    logic              wr;
    logic [WORD_W-1:0] addr;
    logic [WORD_W-1:0] data;
  } draw_op_t;

endpackage

// File: rtl/vram_raster.sv
module vram_raster #(
  parameter int H_ACT = 640,
  parameter int H_FP  = 16,
  parameter int H_SW  = 96,
  parameter int H_BP  = 48,
  parameter int V_ACT = 480,
  parameter int V_FP  = 10,
  parameter int V_SW  = 2,
  parameter int V_BP  = 33,
  parameter int PXW   = 4
) (
  input  logic           clk,
  input  logic           rst,
  output logic [PXW-1:0] px,
  output logic           grp_act,
  output logic           frame_last,
  output logic           hs_raw,
  output logic           vs_raw
);

  localparam int H_TOT = H_ACT + H_FP + H_SW + H_BP;
  localparam int V_TOT = V_ACT + V_FP + V_SW + V_BP;
  localparam int HCW   = $clog2(H_TOT);
  localparam int VCW   = $clog2(V_TOT);
  localparam int H_SS  = H_ACT + H_FP;
  localparam int H_SE  = H_SS + H_SW;
  localparam int V_SS  = V_ACT + V_FP;
  localparam int V_SE  = V_SS + V_SW;

  logic [HCW-1:0] hcnt;
  logic [VCW-1:0] vcnt;
  logic           h_last, v_last;

  assign h_last = (hcnt == HCW'(H_TOT - 1));
  assign v_last = (vcnt == VCW'(V_TOT - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      hcnt <= '0;
      vcnt <= '0;
    end else if (h_last) begin
      hcnt <= '0;
      vcnt <= v_last ? '0 : vcnt + 1'b1;
    end else begin
      hcnt <= hcnt + 1'b1;
    end
  end

  assign px         = hcnt[PXW-1:0];
  assign frame_last = h_last && v_last;
  assign grp_act    = (hcnt < HCW'(H_ACT)) && (vcnt < VCW'(V_ACT));
  assign hs_raw     = (hcnt >= HCW'(H_SS)) && (hcnt < HCW'(H_SE));
  assign vs_raw     = (vcnt >= VCW'(V_SS)) && (vcnt < VCW'(V_SE));

endmodule

// File: rtl/vram_delay.sv
module vram_delay #(
  parameter int           W       = 1,
  parameter int           DEPTH   = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);

  if (DEPTH == 1) begin : g_single
    always_ff @(posedge clk) begin
      if (rst) dout <= RST_VAL;
      else     dout <= din;
    end
  end else begin : g_chain
    logic [DEPTH-1:0][W-1:0] stg;
    always_ff @(posedge clk) begin
      if (rst) stg <= {DEPTH{RST_VAL}};
      else     stg <= {stg[DEPTH-2:0], din};
    end
    assign dout = stg[DEPTH-1];
  end

endmodule

// File: rtl/vram_bus_seq.sv
module vram_bus_seq
  import vram_pkg::*;
#(
  parameter int PXW     = 4,
  parameter int DISP_PX = 0,
  parameter int DRAW_PX = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [PXW-1:0]    px,
  input  logic              disp_go,
  input  logic [WORD_W-1:0] disp_addr,
  input  logic              draw_go,
  input  draw_op_t          draw_op,
  input  logic [WORD_W-1:0] mem_ad_in,
  output logic              mem_ale,
  output logic              mem_ad_oe,
  output logic              mem_we,
  output logic [WORD_W-1:0] mem_ad_out,
  output logic [WORD_W-1:0] disp_word,
  output logic [WORD_W-1:0] rd_word,
  output logic              rd_valid
);

  logic disp_adr_ph, disp_cap_ph, draw_adr_ph, draw_dat_ph, draw_cap_ph;

  assign disp_adr_ph = disp_go && (px == PXW'(DISP_PX));
  assign disp_cap_ph = disp_go && (px == PXW'(DISP_PX + CAP_LAG));
  assign draw_adr_ph = draw_go && (px == PXW'(DRAW_PX));
  assign draw_dat_ph = draw_go && draw_op.wr && (px == PXW'(DRAW_PX + 1));
  assign draw_cap_ph = draw_go && !draw_op.wr && (px == PXW'(DRAW_PX + CAP_LAG));

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_ale    <= 1'b0;
      mem_ad_oe  <= 1'b0;
      mem_we     <= 1'b0;
      mem_ad_out <= '0;
      disp_word  <= '0;
      rd_word    <= '0;
      rd_valid   <= 1'b0;
    end else begin
      mem_ale   <= disp_adr_ph || draw_adr_ph;
      mem_we    <= draw_dat_ph;
      mem_ad_oe <= disp_adr_ph || draw_adr_ph || draw_dat_ph;
      rd_valid  <= draw_cap_ph;
      if (disp_adr_ph)      mem_ad_out <= disp_addr;
      else if (draw_adr_ph) mem_ad_out <= draw_op.addr;
      else if (draw_dat_ph) mem_ad_out <= draw_op.data;
      if (disp_cap_ph) disp_word <= mem_ad_in;
      if (draw_cap_ph) rd_word   <= mem_ad_in;
    end
  end

endmodule

// File: rtl/vram_serializer.sv
module vram_serializer #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_word,
  input  logic         load_vis,
  output logic         pix
);

  logic [W-1:0] sh;
  logic         vis;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh  <= '0;
      vis <= 1'b0;
      pix <= 1'b0;
    end else begin
      pix <= sh[W-1] & vis;
      if (load) begin
        sh  <= load_word;
        vis <= load_vis;
      end else begin
        sh  <= {sh[W-2:0], 1'b0};
      end
    end
  end

endmodule

// File: rtl/mono_vram_ctrl.sv
module mono_vram_ctrl
  import vram_pkg::*;
#(
  parameter int ADDR_W = 15,
  parameter int H_ACT  = 640,
  parameter int H_FP   = 16,
  parameter int H_SW   = 96,
  parameter int H_BP   = 48,
  parameter int V_ACT  = 480,
  parameter int V_FP   = 10,
  parameter int V_SW   = 2,
  parameter int V_BP   = 33
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] disp_base,
  input  logic              draw_req,
  input  logic              draw_we,
  input  logic [ADDR_W-1:0] draw_addr,
  input  logic [15:0]       draw_wdata,
  output logic              draw_ack,
  output logic [15:0]       draw_rdata,
  output logic              draw_rvalid,
  output logic              mem_ale,
  output logic              mem_ad_oe,
  output logic              mem_we,
  output logic [15:0]       mem_ad_out,
  input  logic [15:0]       mem_ad_in,
  output logic              pix_out,
  output logic              hsync_n,
  output logic              vsync_n
);

  localparam int PXW     = $clog2(WORD_W);
  localparam int DISP_PX = 0;
  localparam int DRAW_PX = WORD_W / 2;
  localparam int LAT     = WORD_W + 1;   // one fetch period plus the pixel register

  logic [PXW-1:0] px;
  logic           grp_act, frame_last, hs_raw, vs_raw;

  vram_raster #(
    .H_ACT(H_ACT), .H_FP(H_FP), .H_SW(H_SW), .H_BP(H_BP),
    .V_ACT(V_ACT), .V_FP(V_FP), .V_SW(V_SW), .V_BP(V_BP),
    .PXW(PXW)
  ) u_raster (
    .clk        (clk),
    .rst        (rst),
    .px         (px),
    .grp_act    (grp_act),
    .frame_last (frame_last),
    .hs_raw     (hs_raw),
    .vs_raw     (vs_raw)
  );

  // Refresh address: linear walk from the base, reloaded once per frame.
  logic [ADDR_W-1:0] dptr;

  always_ff @(posedge clk) begin
    if (rst || frame_last)                       dptr <= disp_base;
    else if (grp_act && px == PXW'(DISP_PX))     dptr <= dptr + 1'b1;
  end

  // Drawing request is sampled once per period, just before its slot.
  draw_op_t op_q;
  logic     op_vld;

  always_ff @(posedge clk) begin
    if (rst) begin
      op_vld   <= 1'b0;
      draw_ack <= 1'b0;
      op_q     <= '0;
    end else begin
      draw_ack <= 1'b0;
      if (px == PXW'(DRAW_PX - 1)) begin
        op_vld   <= draw_req;
        draw_ack <= draw_req;
        if (draw_req) op_q <= '{wr: draw_we, addr: WORD_W'(draw_addr), data: draw_wdata};
      end
    end
  end

  logic [WORD_W-1:0] disp_word;

  vram_bus_seq #(
    .PXW(PXW), .DISP_PX(DISP_PX), .DRAW_PX(DRAW_PX)
  ) u_bus (
    .clk        (clk),
    .rst        (rst),
    .px         (px),
    .disp_go    (grp_act),
    .disp_addr  (WORD_W'(dptr)),
    .draw_go    (op_vld),
    .draw_op    (op_q),
    .mem_ad_in  (mem_ad_in),
    .mem_ale    (mem_ale),
    .mem_ad_oe  (mem_ad_oe),
    .mem_we     (mem_we),
    .mem_ad_out (mem_ad_out),
    .disp_word  (disp_word),
    .rd_word    (draw_rdata),
    .rd_valid   (draw_rvalid)
  );

  vram_serializer #(.W(WORD_W)) u_ser (
    .clk       (clk),
    .rst       (rst),
    .load      (px == PXW'(WORD_W - 1)),
    .load_word (disp_word),
    .load_vis  (grp_act),
    .pix       (pix_out)
  );

  vram_delay #(.W(2), .DEPTH(LAT), .RST_VAL(2'b11)) u_sync_dly (
    .clk  (clk),
    .rst  (rst),
    .din  ({~hs_raw, ~vs_raw}),
    .dout ({hsync_n, vsync_n})
  );

endmodule

// File: rtl/vram_check.sv
module vram_check (
  input logic clk,
  input logic rst,
  input logic draw_req,
  input logic draw_ack,
  input logic draw_rvalid,
  input logic mem_ale,
  input logic mem_we,
  input logic mem_ad_oe
);

  // R7: acknowledge is a single clock and answers a request seen the clock before
  a_r7_ack_single: assert property (@(posedge clk) disable iff (rst)
    draw_ack |=> !draw_ack);
  a_r7_ack_needs_req: assert property (@(posedge clk) disable iff (rst)
    draw_ack |-> $past(draw_req));

  // R9: read strobe lags its acknowledge by four clocks
  a_r9_rvalid_after_ack: assert property (@(posedge clk) disable iff (rst)
    draw_rvalid |-> $past(draw_ack, 4));

  // R10: each access has exactly one address phase
  a_r10_ale_single: assert property (@(posedge clk) disable iff (rst)
    mem_ale |=> !mem_ale);

  // R8: write data phase directly follows an address phase and owns the bus
  a_r8_we_after_ale: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> ($past(mem_ale) && mem_ad_oe));

endmodule

bind mono_vram_ctrl vram_check u_vram_check (
  .clk         (clk),
  .rst         (rst),
  .draw_req    (draw_req),
  .draw_ack    (draw_ack),
  .draw_rvalid (draw_rvalid),
  .mem_ale     (mem_ale),
  .mem_we      (mem_we),
  .mem_ad_oe   (mem_ad_oe)
);

// File: tb/test_mono_vram_ctrl.sv
`timescale 1ns/1ps
module test_mono_vram_ctrl;

  localparam int HA = 64, HF = 16, HS = 16, HB = 32;
  localparam int VA = 4,  VF = 1,  VS = 1,  VB = 2;
  localparam int HT = HA + HF + HS + HB;
  localparam int VT = VA + VF + VS + VB;
  localparam int AW = 10;
  localparam int BASE = 64;
  localparam int LATC = 17;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] disp_base = AW'(BASE);
  logic          draw_req = 1'b0, draw_we = 1'b0;
  logic [AW-1:0] draw_addr = '0;
  logic [15:0]   draw_wdata = '0;
  logic          draw_ack, draw_rvalid, mem_ale, mem_ad_oe, mem_we;
  logic [15:0]   draw_rdata, mem_ad_out, mem_ad_in;
  logic          pix_out, hsync_n, vsync_n;

  always #5 clk = ~clk;

  mono_vram_ctrl #(
    .ADDR_W(AW), .H_ACT(HA), .H_FP(HF), .H_SW(HS), .H_BP(HB),
    .V_ACT(VA), .V_FP(VF), .V_SW(VS), .V_BP(VB)
  ) i_mono_vram_ctrl (
    .clk(clk), .rst(rst), .disp_base(disp_base),
    .draw_req(draw_req), .draw_we(draw_we), .draw_addr(draw_addr), .draw_wdata(draw_wdata),
    .draw_ack(draw_ack), .draw_rdata(draw_rdata), .draw_rvalid(draw_rvalid),
    .mem_ale(mem_ale), .mem_ad_oe(mem_ad_oe), .mem_we(mem_we),
    .mem_ad_out(mem_ad_out), .mem_ad_in(mem_ad_in),
    .pix_out(pix_out), .hsync_n(hsync_n), .vsync_n(vsync_n)
  );

  // Memory model: address latch plus word array.
  logic [15:0]   mem [1 << AW];
  logic [AW-1:0] lat = '0;
  always @(posedge clk) begin
    if (mem_ale) lat <= mem_ad_out[AW-1:0];
    if (mem_we)  mem[lat] <= mem_ad_out;
  end
  assign mem_ad_in = mem[lat];

  int tcount = 0;
  always @(posedge clk) begin
    if (rst) tcount <= 0;
    else     tcount <= tcount + 1;
  end

  int n_chk = 0, n_fail = 0;
  bit run_mon = 0, pix_en = 0, done = 0, pend = 0;
  bit          op_we;
  logic [AW-1:0] op_addr;
  logic [15:0]   op_data;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h (t=%0d)", tag, act, exp, tcount);
    end
  endtask

  function automatic bit vis(input int c);
    int h = c % HT;
    int v = (c / HT) % VT;
    return (h < HA) && (v < VA);
  endfunction

  function automatic int widx(input int c);
    int h = c % HT;
    int v = (c / HT) % VT;
    return BASE + v * (HA / 16) + h / 16;
  endfunction

  // Cycle-by-cycle monitor of bus, handshake, syncs and pixels.
  always @(negedge clk) begin
    int c, px, p, h, v;
    bit e_ale, e_we, e_rv, e_pix, e_hs, e_vs;
    if (!rst && run_mon) begin
      c  = tcount;
      px = c % 16;
      if (draw_ack) begin
        chk(px == 8, "R7 ack position", px, 8);
        pend = 1;
      end
      e_ale = (px == 1 && c >= 1 && vis(c - 1)) || (px == 9 && pend);
      chk(mem_ale == e_ale, "R10 address phase slot", mem_ale, e_ale);
      if (px == 1 && c >= 1 && vis(c - 1))
        chk(mem_ad_out == 16'(widx(c - 1)), "R2 display address", mem_ad_out, widx(c - 1));
      if (px == 9 && pend)
        chk(mem_ad_out == 16'(op_addr), "R8 draw address", mem_ad_out, op_addr);
      e_we = (px == 10) && pend && op_we;
      chk(mem_we == e_we, "R10 write strobe slot", mem_we, e_we);
      if (e_we) chk(mem_ad_out == op_data, "R8 write data", mem_ad_out, op_data);
      e_rv = (px == 12) && pend && !op_we;
      chk(draw_rvalid == e_rv, "R9 read strobe", draw_rvalid, e_rv);
      if (e_rv) chk(draw_rdata == mem[op_addr], "R9 read data", draw_rdata, mem[op_addr]);
      if (px == 12) pend = 0;

      p = c - LATC;
      h = (p < 0) ? 0 : p % HT;
      v = (p < 0) ? 0 : (p / HT) % VT;
      e_hs = (p < 0) ? 1'b1 : !(h >= HA + HF && h < HA + HF + HS);
      e_vs = (p < 0) ? 1'b1 : !(v >= VA + VF && v < VA + VF + VS);
      chk(hsync_n == e_hs, "R5 hsync", hsync_n, e_hs);
      chk(vsync_n == e_vs, "R6 vsync", vsync_n, e_vs);
      if (pix_en) begin
        if (p >= 0 && vis(p)) begin
          e_pix = mem[widx(p)][15 - (p % 16)];
          chk(pix_out == e_pix, "R3 serial pixel", pix_out, e_pix);
        end else begin
          chk(pix_out == 1'b0, "R4 blanking", pix_out, 0);
        end
      end
    end
  end

  task automatic draw_op(input bit we, input logic [AW-1:0] a, input logic [15:0] d,
                         input int start_px, input string tag);
    int t0, lat_exp, guard;
    while ((tcount % 16) != start_px) @(negedge clk);
    op_we = we; op_addr = a; op_data = d;
    draw_we = we; draw_addr = a; draw_wdata = d; draw_req = 1'b1;
    t0 = tcount;
    lat_exp = (start_px <= 7) ? (8 - start_px) : (24 - start_px);
    guard = 0;
    do begin
      @(negedge clk);
      guard++;
    end while (!draw_ack && guard < 100);
    draw_req = 1'b0;
    chk(tcount - t0 == lat_exp, tag, tcount - t0, lat_exp);
    repeat (8) @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < (1 << AW); i++) mem[i] = 16'((i * 40503 + 12345) ^ (i << 7));
    repeat (4) @(negedge clk);
    // R1: reset values
    chk(pix_out == 1'b0,     "R1 pix_out",     pix_out, 0);
    chk(hsync_n == 1'b1,     "R1 hsync_n",     hsync_n, 1);
    chk(vsync_n == 1'b1,     "R1 vsync_n",     vsync_n, 1);
    chk(mem_ale == 1'b0,     "R1 mem_ale",     mem_ale, 0);
    chk(mem_we == 1'b0,      "R1 mem_we",      mem_we, 0);
    chk(draw_ack == 1'b0,    "R1 draw_ack",    draw_ack, 0);
    chk(draw_rvalid == 1'b0, "R1 draw_rvalid", draw_rvalid, 0);
    rst = 1'b0;
    run_mon = 1; pix_en = 1;
    repeat (2 * HT * VT) @(negedge clk);
    pix_en = 0;
    // Drawing traffic, including mid-period requests
    draw_op(1'b1, 10'h3F0, 16'hBEEF, 3, "R7 ack latency from position 3");
    chk(mem[10'h3F0] == 16'hBEEF, "R8 write above frame landed", mem[10'h3F0], 16'hBEEF);
    draw_op(1'b0, 10'h3F0, 16'h0000, 9, "R7 ack latency from position 9");
    draw_op(1'b0, 10'h045, 16'h0000, 7, "R7 ack latency from position 7");
    draw_op(1'b1, 10'h045, 16'hF00F, 12, "R7 ack latency from position 12");
    chk(mem[10'h045] == 16'hF00F, "R10 frame word written", mem[10'h045], 16'hF00F);
    draw_op(1'b0, 10'h045, 16'h0000, 0, "R7 ack latency from position 0");
    // R10: written frame word must appear from the next full frame
    while ((tcount % (HT * VT)) != 0) @(negedge clk);
    pix_en = 1;
    repeat (HT * VT + 100) @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule